// File: doc/BRIEF.md
# Write-Leveling Phase Retry Sequencer

This block is used during memory interface bring-up. It walks a range of byte lanes in ascending order. For each lane enabled in a lane mask, it reads that lane's leveling register once and keeps the 3-bit coarse phase it finds there. It then asks an external lane checker for a verdict.

When the checker rejects the lane, the sequencer does not sweep every phase. It tries up to three alternative phases, always derived from the saved original value: first two steps earlier, then two steps later, then four steps later. Each alternative is written back only when it stays inside the legal range. The checker is consulted again after every attempt, including attempts where no write was made.

A lane that is still rejected after the fourth verdict sets a sticky failure flag, and the walk moves on to the next lane. The block raises `done` for one cycle once the range is exhausted. Register accesses and checker requests use simple request/acknowledge handshakes, so the sequencer can sit beside a slow configuration bus.

Top module: `wl_phase_retry_seq`

## Requirements
- R1: The coarse phase is the 3-bit field at register bits [8:6]. Each active lane's register is read exactly once, before its first verdict, and every retry value is computed from that saved read.
- R2: The first verdict for a lane is taken at the unchanged phase. A pass ends the lane with no register write.
- R3: After the first rejection, a saved phase above 1 is written back as phase minus 2. A saved phase of exactly 1 is written back with bits [4:0] and [8:6] cleared. A saved phase of 0 causes no write. In every case a second verdict follows.
- R4: After the second rejection, a saved phase of 5 or less is written back as phase plus 2. Otherwise no write is made. A third verdict follows in both cases.
- R5: After the third rejection, a saved phase of 3 or less is written back as phase plus 4. Otherwise no write is made. A fourth verdict follows in both cases.
- R6: A fourth rejection ends the lane and sets the failure flag. Lanes that come later in the range are still processed.
- R7: A lane whose bit is 0 in the lane mask sees no register access and no checker request.
- R8: Lanes are visited in ascending order from `first_lane` up to, but not including, `end_lane`. Lanes outside that range are never touched. An empty range completes with no access.
- R9: Every retry write keeps all register bits outside [8:6] exactly as they were read, except in the saved-phase-of-1 case described in R3.
- R10: `done` is a single-cycle pulse after the last lane. `fail` is valid while `done` is high, stays unchanged until the next accepted `start`, and is cleared by that `start`.
- R11: `reg_req` and `cmp_req` are never high together. Each request holds its lane, direction and write data stable until it is acknowledged. A `start` that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| first_lane | input | IDX_W | First lane index of the walk |
| end_lane | input | IDX_W | Exclusive end lane index |
| lane_mask | input | NUM_LANES | 1 marks a lane as active; latched at start |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 for a write, 0 for a read |
| reg_lane | output | IDX_W | Lane whose register is accessed |
| reg_wdata | output | REG_W | Write data |
| reg_rdata | input | REG_W | Read data, valid with reg_ack |
| reg_ack | input | 1 | Register access completed |
| cmp_req | output | 1 | Verdict request for cmp_lane |
| cmp_lane | output | IDX_W | Lane being judged |
| cmp_ack | input | 1 | Verdict available |
| cmp_pass | input | 1 | Verdict, valid with cmp_ack |
| done | output | 1 | One-cycle end-of-walk pulse |
| fail | output | 1 | Sticky failure flag |

## Verification
The hardest paths to reach are the late retry steps. In these, the saved phase forbids a write, so the sequencer must ask the checker again without changing anything. A run reaches the fourth verdict only when every candidate phase of a lane is rejected.

The bench attaches a model register file and a model checker. The checker judges each lane against an 8-bit table of acceptable phases, indexed by the lane's current phase. The sweep pairs every starting phase with every one of the 256 acceptance tables, spread over four lanes per walk. This covers each early-exit point, each guarded no-write step and each exhausted lane, all with varied surrounding register bits.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_READ,
      ST_CMP,
      ST_WRITE,
      ST_DONE
   } wlr_state_t;

   localparam int unsigned LAST_ATTEMPT = 3;
endpackage

// File: rtl/wlr_retry_plan.sv
module wlr_retry_plan #(
   parameter int unsigned REG_W          = 16,
   parameter int unsigned PHASE_LSB      = 6,
   parameter int unsigned PHASE_W        = 3,
   parameter bit          ONE_CLEARS_LOW = 1'b1
) (
   input  logic [REG_W-1:0] saved,
   input  logic [1:0]       attempt,
   output logic             wr_en,
   output logic [REG_W-1:0] wdata
);
   localparam int MAXP = (1 << PHASE_W) - 1;
   localparam logic [REG_W-1:0] FIELD_MASK =
      {{(REG_W-PHASE_W){1'b0}}, {PHASE_W{1'b1}}} << PHASE_LSB;
   localparam logic [REG_W-1:0] LOW_MASK =
      {{(REG_W-PHASE_LSB+1){1'b0}}, {(PHASE_LSB-1){1'b1}}};

   if (PHASE_W < 3)                 $error("PHASE_W must hold +4");
   if (PHASE_LSB < 2)               $error("PHASE_LSB too small");
   if (PHASE_LSB + PHASE_W > REG_W) $error("phase field outside register");

   logic [REG_W-1:0] one_clr;
   if (ONE_CLEARS_LOW) begin : g_low
      assign one_clr = FIELD_MASK | LOW_MASK;
   end else begin : g_fld
      assign one_clr = FIELD_MASK;
   end

   logic [PHASE_W-1:0] orig;
   assign orig = saved[PHASE_LSB +: PHASE_W];

   function automatic logic [REG_W-1:0] put(input logic [REG_W-1:0] v,
                                            input logic [PHASE_W-1:0] p);
      put = (v & ~FIELD_MASK) | ({{(REG_W-PHASE_W){1'b0}}, p} << PHASE_LSB);
   endfunction

   always_comb begin
      wr_en = 1'b0;
      wdata = saved;
      unique case (attempt)
         2'd1: begin
            if (int'(orig) > 1) begin
               wr_en = 1'b1;
               wdata = put(saved, orig - PHASE_W'(2));
            end else if (int'(orig) == 1) begin
               wr_en = 1'b1;
               wdata = saved & ~one_clr;
            end
         end
         2'd2: begin
            if (int'(orig) <= MAXP - 2) begin
               wr_en = 1'b1;
               wdata = put(saved, orig + PHASE_W'(2));
            end
         end
         2'd3: begin
            if (int'(orig) <= MAXP - 4) begin
               wr_en = 1'b1;
               wdata = put(saved, orig + PHASE_W'(4));
            end
         end
         default: ;
      endcase
   end

   // R3/R4/R5: a planned write never lands on the phase it left
   always_comb begin
      if (wr_en && attempt != 2'd1)
         a_r4_moves_phase: assert (wdata[PHASE_LSB +: PHASE_W] != orig);
   end
endmodule

// File: rtl/wlr_lane_walk.sv
module wlr_lane_walk #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned IDX_W     = $clog2(NUM_LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [IDX_W-1:0]     first,
   input  logic [IDX_W-1:0]     end_excl,
   input  logic [NUM_LANES-1:0] mask_in,
   input  logic                 advance,
   output logic [IDX_W-1:0]     lane,
   output logic                 in_range,
   output logic                 active
);
   if (NUM_LANES < 1)              $error("need at least one lane");
   if ((1 << IDX_W) <= NUM_LANES)  $error("IDX_W cannot index end of range");

   logic [IDX_W-1:0]     end_q;
   logic [NUM_LANES-1:0] mask_q;
   logic [NUM_LANES-1:0] sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane   <= '0;
         end_q  <= '0;
         mask_q <= '0;
      end else if (load) begin
         lane   <= first;
         end_q  <= end_excl;
         mask_q <= mask_in;
      end else if (advance) begin
         lane   <= lane + IDX_W'(1);
      end
   end

   assign sel      = mask_q >> lane;
   assign in_range = (lane < end_q) && (int'(lane) < NUM_LANES);
   assign active   = in_range && sel[0];

   // R8: the walk only steps while inside its range
   a_r8_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> in_range);
   a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (lane == $past(lane) + IDX_W'(1)));
endmodule

// File: rtl/wl_phase_retry_seq.sv
module wl_phase_retry_seq
   import wlr_pkg::*;
#(
   parameter int unsigned NUM_LANES      = 4,
   parameter int unsigned REG_W          = 16,
   parameter int unsigned PHASE_LSB      = 6,
   parameter int unsigned PHASE_W        = 3,
   parameter bit          ONE_CLEARS_LOW = 1'b1,
   parameter int unsigned IDX_W          = $clog2(NUM_LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IDX_W-1:0]     first_lane,
   input  logic [IDX_W-1:0]     end_lane,
   input  logic [NUM_LANES-1:0] lane_mask,
   output logic                 reg_req,
   output logic                 reg_wr,
   output logic [IDX_W-1:0]     reg_lane,
   output logic [REG_W-1:0]     reg_wdata,
   input  logic [REG_W-1:0]     reg_rdata,
   input  logic                 reg_ack,
   output logic                 cmp_req,
   output logic [IDX_W-1:0]     cmp_lane,
   input  logic                 cmp_ack,
   input  logic                 cmp_pass,
   output logic                 done,
   output logic                 fail
);
   localparam logic [REG_W-1:0] FIELD_MASK =
      {{(REG_W-PHASE_W){1'b0}}, {PHASE_W{1'b1}}} << PHASE_LSB;

   wlr_state_t       state;
   logic [REG_W-1:0] saved;
   logic [1:0]       attempt;
   logic [1:0]       plan_att;
   logic             plan_wr;
   logic [REG_W-1:0] plan_data;
   logic             load, advance;
   logic [IDX_W-1:0] lane;
   logic             in_range, active;
   logic             fail_q;

   assign load     = (state == ST_IDLE) && start;
   assign plan_att = (state == ST_WRITE) ? attempt : attempt + 2'd1;

   always_comb begin
      advance = 1'b0;
      if (state == ST_SCAN && in_range && !active)
         advance = 1'b1;
      if (state == ST_CMP && cmp_ack &&
          (cmp_pass || int'(attempt) == LAST_ATTEMPT))
         advance = 1'b1;
   end

   wlr_lane_walk #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .first    (first_lane),
      .end_excl (end_lane),
      .mask_in  (lane_mask),
      .advance  (advance),
      .lane     (lane),
      .in_range (in_range),
      .active   (active)
   );

   wlr_retry_plan #(
      .REG_W(REG_W), .PHASE_LSB(PHASE_LSB), .PHASE_W(PHASE_W),
      .ONE_CLEARS_LOW(ONE_CLEARS_LOW)
   ) u_plan (
      .saved   (saved),
      .attempt (plan_att),
      .wr_en   (plan_wr),
      .wdata   (plan_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         saved   <= '0;
         attempt <= '0;
         fail_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               fail_q <= 1'b0;
               state  <= ST_SCAN;
            end
            ST_SCAN: begin
               if (!in_range)   state <= ST_DONE;
               else if (active) state <= ST_READ;
            end
            ST_READ: if (reg_ack) begin
               saved   <= reg_rdata;
               attempt <= '0;
               state   <= ST_CMP;
            end
            ST_CMP: if (cmp_ack) begin
               if (cmp_pass) begin
                  state <= ST_SCAN;
               end else if (int'(attempt) == LAST_ATTEMPT) begin
                  fail_q <= 1'b1;
                  state  <= ST_SCAN;
               end else begin
                  attempt <= attempt + 2'd1;
                  state   <= plan_wr ? ST_WRITE : ST_CMP;
               end
            end
            ST_WRITE: if (reg_ack) state <= ST_CMP;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign reg_req   = (state == ST_READ) || (state == ST_WRITE);
   assign reg_wr    = (state == ST_WRITE);
   assign reg_lane  = lane;
   assign reg_wdata = reg_wr ? plan_data : '0;
   assign cmp_req   = (state == ST_CMP);
   assign cmp_lane  = lane;
   assign done      = (state == ST_DONE);
   assign fail      = fail_q;

   // R11: handshake discipline
   a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_req && cmp_req));
   a_r11_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_lane) &&
                                 $stable(reg_wr) && $stable(reg_wdata)));
   a_r11_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_req && !cmp_ack) |=> (cmp_req && $stable(cmp_lane)));
   // R7: requests only for active lanes
   a_r7_active_only: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req || cmp_req) |-> active);
   // R9: retry writes keep non-phase bits, unless saved phase is 1
   a_r9_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_wr && int'(saved[PHASE_LSB +: PHASE_W]) != 1) |->
         (((reg_wdata ^ saved) & ~FIELD_MASK) == '0));
   // R10: done pulse and fail clear on start
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !fail);
   a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> $stable(fail));
endmodule

// File: tb/wl_phase_retry_seq_bench.sv
module wl_phase_retry_seq_bench;
   localparam int NL = 4;
   localparam int IW = 3;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IW-1:0] first_lane = '0, end_lane = '0;
   logic [NL-1:0] lane_mask = '0;
   logic          reg_req, reg_wr;
   logic [IW-1:0] reg_lane, cmp_lane;
   logic [RW-1:0] reg_wdata;
   logic [RW-1:0] reg_rdata = '0;
   logic          reg_ack = 1'b0;
   logic          cmp_req;
   logic          cmp_ack = 1'b0, cmp_pass = 1'b0;
   logic          done, fail;

   always #4 clk = ~clk;

   wl_phase_retry_seq u_wl_phase_retry_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .first_lane(first_lane),
      .end_lane(end_lane), .lane_mask(lane_mask), .reg_req(reg_req),
      .reg_wr(reg_wr), .reg_lane(reg_lane), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_ack(reg_ack), .cmp_req(cmp_req),
      .cmp_lane(cmp_lane), .cmp_ack(cmp_ack), .cmp_pass(cmp_pass),
      .done(done), .fail(fail));

   int vecs = 0, errs = 0;
   logic [RW-1:0] regs [NL];
   logic [7:0]    goodm [NL];
   int rd_cnt [NL];
   int wr_cnt [NL];
   int cmp_cnt [NL];
   int last_rd;
   bit order_bad;
   bit both_req;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // model register file and model checker
   initial begin
      forever begin
         @(negedge clk);
         if (reg_req && cmp_req) both_req = 1'b1;
         if (reg_req && !reg_ack) begin
            reg_ack = 1'b1;
            if (reg_wr) begin
               regs[reg_lane[1:0]] = reg_wdata;
               wr_cnt[reg_lane[1:0]]++;
            end else begin
               reg_rdata = regs[reg_lane[1:0]];
               rd_cnt[reg_lane[1:0]]++;
               if (int'(reg_lane) <= last_rd) order_bad = 1'b1;
               last_rd = int'(reg_lane);
            end
         end else reg_ack = 1'b0;
         if (cmp_req && !cmp_ack) begin
            cmp_ack  = 1'b1;
            cmp_pass = goodm[cmp_lane[1:0]][regs[cmp_lane[1:0]][8:6]];
            cmp_cnt[cmp_lane[1:0]]++;
         end else cmp_ack = 1'b0;
      end
   end

   // arithmetic expectation for one lane
   task automatic expect_lane(input logic [RW-1:0] v, input logic [7:0] g,
                              output logic [RW-1:0] fin, output int nwr,
                              output bit bad);
      int o = int'(v[8:6]);
      logic [RW-1:0] cur = v;
      nwr = 0; bad = 1'b1;
      for (int a = 0; a < 4; a++) begin
         if (g[cur[8:6]]) begin bad = 1'b0; break; end
         if (a == 0) begin
            if (o > 1) begin cur[8:6] = 3'(o - 2); nwr++; end
            else if (o == 1) begin cur = v & ~16'h01DF; nwr++; end
         end else if (a == 1) begin
            if (o <= 5) begin cur = v; cur[8:6] = 3'(o + 2); nwr++; end
         end else if (a == 2) begin
            if (o <= 3) begin cur = v; cur[8:6] = 3'(o + 4); nwr++; end
         end
      end
      fin = cur;
   endtask

   task automatic run(input int f, input int e, input logic [NL-1:0] m,
                      input bit restart_mid);
      logic [RW-1:0] init [NL];
      logic [RW-1:0] fin;
      int nwr, wait_cyc;
      bit bad, exp_fail;
      exp_fail = 1'b0;
      for (int i = 0; i < NL; i++) begin
         init[i] = regs[i];
         rd_cnt[i] = 0; wr_cnt[i] = 0; cmp_cnt[i] = 0;
      end
      last_rd = -1; order_bad = 1'b0;
      @(negedge clk);
      first_lane = IW'(f); end_lane = IW'(e); lane_mask = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!fail, "R10 fail cleared by start", int'(fail), 0);
      if (restart_mid) begin
         repeat (3) @(negedge clk);
         first_lane = IW'(NL); end_lane = '0; lane_mask = '0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_cyc = 0;
      while (!done && wait_cyc < 2000) begin
         @(negedge clk);
         wait_cyc++;
      end
      chk(done, "R10 done reached", int'(done), 1);
      for (int i = 0; i < NL; i++) begin
         if (i >= f && i < e && m[i]) begin
            expect_lane(init[i], goodm[i], fin, nwr, bad);
            if (bad) exp_fail = 1'b1;
            chk(regs[i] == fin, "R3 R4 R5 R9 final register", int'(regs[i]), int'(fin));
            chk(wr_cnt[i] == nwr, "R2 R6 write count", wr_cnt[i], nwr);
            chk(rd_cnt[i] == 1, "R1 single read", rd_cnt[i], 1);
            chk(cmp_cnt[i] == (bad ? 4 : cmp_cnt[i]) && cmp_cnt[i] <= 4,
                "R6 verdict count", cmp_cnt[i], bad ? 4 : cmp_cnt[i]);
         end else begin
            chk(rd_cnt[i] + wr_cnt[i] + cmp_cnt[i] == 0, "R7 R8 untouched lane",
                rd_cnt[i] + wr_cnt[i] + cmp_cnt[i], 0);
         end
      end
      chk(fail == exp_fail, "R6 R10 fail at done", int'(fail), int'(exp_fail));
      chk(!order_bad, "R8 ascending order", int'(order_bad), 0);
      @(negedge clk);
      chk(!done, "R10 done single cycle", int'(done), 0);
      repeat (2) @(negedge clk);
      chk(fail == exp_fail, "R10 fail sticky", int'(fail), int'(exp_fail));
   endtask

   int cyc = 0;
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
         end
      end
   end

   initial begin
      both_req = 1'b0;
      for (int i = 0; i < NL; i++) begin regs[i] = '0; goodm[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!done && !fail && !reg_req && !cmp_req, "R10 reset state",
          int'({done, fail, reg_req, cmp_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // sweep: every start phase against every acceptance table
      for (int r = 0; r < 512; r++) begin
         for (int i = 0; i < NL; i++) begin
            int c = r * NL + i;
            logic [RW-1:0] v = RW'(c * 40503 + 16'h5A3C);
            v[8:6] = 3'(c % 8);
            regs[i]  = v;
            goodm[i] = 8'(c / 8);
         end
         run(0, NL, '1, (r % 37) == 5);
      end
      // mask and range corners
      for (int i = 0; i < NL; i++) begin regs[i] = 16'hFFFF; goodm[i] = 8'h02; end
      run(0, NL, 4'b1010, 1'b0);
      run(1, 3, 4'b1111, 1'b0);
      run(2, 2, 4'b1111, 1'b0);
      run(3, 1, 4'b1111, 1'b0);
      run(0, NL, 4'b0000, 1'b0);
      for (int i = 0; i < NL; i++) begin regs[i] = 16'h0040; goodm[i] = 8'h01; end
      run(0, NL, 4'b0110, 1'b0);
      chk(!both_req, "R11 exclusive requests", int'(both_req), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule